// File: doc/BRIEF.md
# Memory Barrier and Write-Drain Controller

This block sits between the load/store issue stage of a simple in-order core and a posted write buffer that feeds a memory port. The core raises a barrier request by writing an operation code to a cache-operation control register. The block supports three operations: a data barrier, a write-buffer drain and a prefetch flush. While a barrier is pending, the block holds off the work that the barrier must order.

The block counts outstanding explicit memory transactions in three saturating counters, one for each completion level: accepted locally, accepted by the interconnect, and final response received. The memory type of each access selects the level at which the access counts as finished. The memory side returns one acknowledge pulse per level, and each pulse retires one access of that level's class.

A data barrier stalls only later memory accesses. A drain also stalls instruction completion and interrupt-mask updates. A prefetch flush always emits a pipeline flush pulse, so that fetched instructions are discarded and fetched again.

Top module: `barrier_ctrl`

## Requirements
- R1: On the request port, `bar_op` 2'b01 selects the data barrier, 2'b10 the drain and 2'b11 the prefetch flush. A valid request with 2'b00 is ignored: `bar_ready` stays 1, no stall rises, and neither `bar_done` nor `pipe_flush` pulses.
- R2: While a data barrier is pending, `mem_stall` is 1, and `insn_stall` and `irq_stall` stay 0. The pending period runs from the cycle after acceptance until completion.
- R3: While a drain is pending, `mem_stall`, `insn_stall` and `irq_stall` are all 1.
- R4: A data barrier or drain completes in the cycle after all three counters read zero. Completion shows as a one-cycle `bar_done` pulse, with `bar_ready` returning to 1 and all stalls dropping to 0. With nothing outstanding, `bar_done` follows one cycle after acceptance.
- R5: A write with `mem_type` 2'b00 (non-shared) is retired by `ack_local`. A write with 2'b01 (shared) is retired by `ack_ic`. A write with 2'b10 or 2'b11 (strongly ordered) is retired by `ack_fin`, and every read is also retired by `ack_fin`. An acknowledge at any other level does not finish the access.
- R6: Each counter is 4 bits wide. It holds at 15 when incremented further and holds at 0 when an acknowledge arrives while it is empty.
- R7: A prefetch flush completes one cycle after acceptance, whatever is outstanding. It raises `pipe_flush` together with `bar_done` for one cycle and asserts no stall.
- R8: `bar_ready` is 0 while a barrier is pending. A request is taken only in a cycle where `bar_valid` and `bar_ready` are both 1, so a request that arrives while another is pending waits until `bar_ready` returns to 1.
- R9: Reset, which is synchronous and active high, clears the counters and any pending barrier. After reset, `bar_ready` is 1 and all stalls and pulses are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bar_valid | input | 1 | Barrier request valid (control-register write) |
| bar_op | input | 2 | Barrier operation code |
| bar_ready | output | 1 | Controller can take a request |
| mem_start | input | 1 | An explicit memory access starts this cycle |
| mem_is_write | input | 1 | The starting access is a write |
| mem_type | input | 2 | Memory type of the starting access |
| ack_local | input | 1 | One non-shared write has been accepted locally |
| ack_ic | input | 1 | One shared write has been accepted by the interconnect |
| ack_fin | input | 1 | One strongly ordered write or read has received its final response |
| mem_stall | output | 1 | Hold later memory accesses |
| insn_stall | output | 1 | Hold instruction completion |
| irq_stall | output | 1 | Hold interrupt-mask updates |
| bar_done | output | 1 | One-cycle completion pulse |
| pipe_flush | output | 1 | One-cycle pipeline flush pulse |

## Verification
The bench builds the block with the default counter width of 4 bits. At that width, seventeen non-shared writes push the local counter past its ceiling of 15. Fifteen acknowledges then empty it, so the bench can see saturation as a drain that completes only after the fifteenth acknowledge. The short width also keeps the mixed-type scenarios small. In those scenarios, acknowledges at the wrong level must leave a drain pending, and a second request must wait behind the first.

// File: rtl/barrier_pkg.sv
package barrier_pkg;

  typedef enum logic [1:0] {
    OP_NONE  = 2'b00,
    OP_DMB   = 2'b01,
    OP_DRAIN = 2'b10,
    OP_FLUSH = 2'b11
  } bar_op_e;

  localparam int unsigned NUM_LVL = 3;
  localparam int unsigned LVL_W   = 2;

  localparam logic [LVL_W-1:0] LVL_LOCAL = 2'd0;
  localparam logic [LVL_W-1:0] LVL_IC    = 2'd1;
  localparam logic [LVL_W-1:0] LVL_FIN   = 2'd2;

  // Completion level an access needs before it counts as finished
  function automatic logic [LVL_W-1:0] level_of(input logic is_write,
                                                input logic [1:0] mtype);
    if (!is_write)          return LVL_FIN;
    else if (mtype == 2'b00) return LVL_LOCAL;
    else if (mtype == 2'b01) return LVL_IC;
    else                     return LVL_FIN;
  endfunction

endpackage

// File: rtl/bar_sat_counter.sv
module bar_sat_counter #(
  parameter int unsigned CNT_W = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic inc,
  input  logic dec,
  output logic is_zero
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (inc && !dec && cnt_q != CNT_MAX) begin
      cnt_q <= cnt_q + 1'b1;
    end else if (dec && !inc && cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign is_zero = (cnt_q == '0);

  // R6: saturation at the top
  p_no_overflow_r6: assert property (@(posedge clk) disable iff (rst)
    (cnt_q == CNT_MAX && inc && !dec) |=> (cnt_q == CNT_MAX));

  // R6: no wrap below zero
  p_no_underflow_r6: assert property (@(posedge clk) disable iff (rst)
    (cnt_q == '0 && dec && !inc) |=> (cnt_q == '0));

endmodule

// File: rtl/bar_fsm.sv
module bar_fsm
  import barrier_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       bar_valid,
  input  logic [1:0] bar_op,
  input  logic       all_zero,
  output logic       bar_ready,
  output logic       mem_stall,
  output logic       insn_stall,
  output logic       irq_stall,
  output logic       bar_done,
  output logic       pipe_flush
);
  logic    busy_q;
  bar_op_e op_q;
  logic    accept;
  logic    finish;

  assign accept = !busy_q && bar_valid && (bar_op != OP_NONE);
  assign finish = busy_q && ((op_q == OP_FLUSH) || all_zero);

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q     <= 1'b0;
      op_q       <= OP_NONE;
      mem_stall  <= 1'b0;
      insn_stall <= 1'b0;
      irq_stall  <= 1'b0;
      bar_done   <= 1'b0;
      pipe_flush <= 1'b0;
    end else begin
      bar_done   <= 1'b0;
      pipe_flush <= 1'b0;
      if (accept) begin
        busy_q     <= 1'b1;
        op_q       <= bar_op_e'(bar_op);
        mem_stall  <= (bar_op == OP_DMB) || (bar_op == OP_DRAIN);
        insn_stall <= (bar_op == OP_DRAIN);
        irq_stall  <= (bar_op == OP_DRAIN);
      end else if (finish) begin
        busy_q     <= 1'b0;
        mem_stall  <= 1'b0;
        insn_stall <= 1'b0;
        irq_stall  <= 1'b0;
        bar_done   <= 1'b1;
        pipe_flush <= (op_q == OP_FLUSH);
      end
    end
  end

  assign bar_ready = !busy_q;

  // R3: a drain stalls every scope at once
  p_drain_scope_r3: assert property (@(posedge clk) disable iff (rst)
    insn_stall |-> (mem_stall && irq_stall));

  // R7: flush pulse only comes with completion
  p_flush_with_done_r7: assert property (@(posedge clk) disable iff (rst)
    pipe_flush |-> bar_done);

  // R4: an ordering barrier finishes only after the counters were empty
  p_done_waits_r4: assert property (@(posedge clk) disable iff (rst)
    (bar_done && !pipe_flush) |-> $past(all_zero));

  // R1: a no-op code starts nothing
  p_ignore_nop_r1: assert property (@(posedge clk) disable iff (rst)
    (bar_ready && bar_valid && bar_op == 2'b00) |=> bar_ready);

  // R8: no request taken while busy
  p_hold_op_r8: assert property (@(posedge clk) disable iff (rst)
    (!bar_ready && !finish) |=> ($stable(op_q) && !bar_ready));

endmodule

// File: rtl/barrier_ctrl.sv
module barrier_ctrl
  import barrier_pkg::*;
#(
  parameter int unsigned CNT_W = 4
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       bar_valid,
  input  logic [1:0] bar_op,
  output logic       bar_ready,
  input  logic       mem_start,
  input  logic       mem_is_write,
  input  logic [1:0] mem_type,
  input  logic       ack_local,
  input  logic       ack_ic,
  input  logic       ack_fin,
  output logic       mem_stall,
  output logic       insn_stall,
  output logic       irq_stall,
  output logic       bar_done,
  output logic       pipe_flush
);
  logic [LVL_W-1:0]   lvl;
  logic [NUM_LVL-1:0] lvl_inc;
  logic [NUM_LVL-1:0] lvl_dec;
  logic [NUM_LVL-1:0] lvl_zero;
  logic               all_zero;

  assign lvl     = level_of(mem_is_write, mem_type);
  assign lvl_dec = {ack_fin, ack_ic, ack_local};

  for (genvar g = 0; g < NUM_LVL; g++) begin : g_lvl
    assign lvl_inc[g] = mem_start && (lvl == LVL_W'(g));
    bar_sat_counter #(.CNT_W(CNT_W)) i_cnt (
      .clk     (clk),
      .rst     (rst),
      .inc     (lvl_inc[g]),
      .dec     (lvl_dec[g]),
      .is_zero (lvl_zero[g])
    );
  end

  assign all_zero = &lvl_zero;

  bar_fsm i_fsm (
    .clk        (clk),
    .rst        (rst),
    .bar_valid  (bar_valid),
    .bar_op     (bar_op),
    .all_zero   (all_zero),
    .bar_ready  (bar_ready),
    .mem_stall  (mem_stall),
    .insn_stall (insn_stall),
    .irq_stall  (irq_stall),
    .bar_done   (bar_done),
    .pipe_flush (pipe_flush)
  );

  // R5: one increment per started access, into exactly one class
  p_one_class_r5: assert property (@(posedge clk) disable iff (rst)
    $onehot0(lvl_inc));

  // R2: memory accesses do not start while stalled (core contract)
  p_no_start_stalled_r2: assert property (@(posedge clk) disable iff (rst)
    mem_stall |-> !mem_start);

endmodule

// File: tb/test_barrier_ctrl.sv
module test_barrier_ctrl;
  logic       clk = 1'b0;
  logic       rst;
  logic       bar_valid;
  logic [1:0] bar_op;
  logic       bar_ready;
  logic       mem_start, mem_is_write;
  logic [1:0] mem_type;
  logic       ack_local, ack_ic, ack_fin;
  logic       mem_stall, insn_stall, irq_stall, bar_done, pipe_flush;

  int errors = 0;
  int checks = 0;

  always #5 clk = ~clk;

  barrier_ctrl i_barrier_ctrl (
    .clk(clk), .rst(rst), .bar_valid(bar_valid), .bar_op(bar_op),
    .bar_ready(bar_ready), .mem_start(mem_start), .mem_is_write(mem_is_write),
    .mem_type(mem_type), .ack_local(ack_local), .ack_ic(ack_ic), .ack_fin(ack_fin),
    .mem_stall(mem_stall), .insn_stall(insn_stall), .irq_stall(irq_stall),
    .bar_done(bar_done), .pipe_flush(pipe_flush)
  );

  // vector: [19:16] req tag, [15] valid, [14:13] op, [12] start, [11] write,
  // [10:9] type, [8] ack_local, [7] ack_ic, [6] ack_fin,
  // [5:0] expected {ready, mem_stall, insn_stall, irq_stall, done, flush}
  localparam int NV = 33;
  localparam logic [19:0] VEC [NV] = '{
    {4'd9, 1'b0, 2'b00, 4'b0000, 3'b000, 6'b100000}, // R9 idle
    {4'd2, 1'b1, 2'b01, 4'b0000, 3'b000, 6'b010000}, // R2 data barrier taken
    {4'd4, 1'b0, 2'b00, 4'b0000, 3'b000, 6'b100010}, // R4 done one cycle later
    {4'd4, 1'b0, 2'b00, 4'b0000, 3'b000, 6'b100000},
    {4'd3, 1'b1, 2'b10, 4'b0000, 3'b000, 6'b011100}, // R3 drain taken
    {4'd4, 1'b0, 2'b00, 4'b0000, 3'b000, 6'b100010},
    {4'd7, 1'b1, 2'b11, 4'b0000, 3'b000, 6'b000000}, // R7 flush taken
    {4'd7, 1'b0, 2'b00, 4'b0000, 3'b000, 6'b100011}, // R7 flush pulse
    {4'd1, 1'b1, 2'b00, 4'b0000, 3'b000, 6'b100000}, // R1 code 00 ignored
    {4'd1, 1'b0, 2'b00, 4'b0000, 3'b000, 6'b100000},
    {4'd5, 1'b0, 2'b00, 4'b1100, 3'b000, 6'b100000}, // R5 non-shared write
    {4'd5, 1'b0, 2'b00, 4'b1101, 3'b000, 6'b100000}, // R5 shared write
    {4'd3, 1'b1, 2'b10, 4'b0000, 3'b000, 6'b011100}, // R3 drain
    {4'd5, 1'b0, 2'b00, 4'b0000, 3'b100, 6'b011100}, // R5 local ack
    {4'd5, 1'b0, 2'b00, 4'b0000, 3'b000, 6'b011100},
    {4'd5, 1'b0, 2'b00, 4'b0000, 3'b010, 6'b011100}, // R5 ic ack, now empty
    {4'd4, 1'b0, 2'b00, 4'b0000, 3'b000, 6'b100010}, // R4 done
    {4'd5, 1'b0, 2'b00, 4'b1110, 3'b000, 6'b100000}, // R5 strongly ordered write
    {4'd5, 1'b0, 2'b00, 4'b1000, 3'b000, 6'b100000}, // R5 read
    {4'd7, 1'b1, 2'b11, 4'b0000, 3'b000, 6'b000000}, // R7 flush with work outstanding
    {4'd7, 1'b0, 2'b00, 4'b0000, 3'b000, 6'b100011},
    {4'd2, 1'b1, 2'b01, 4'b0000, 3'b000, 6'b010000}, // R2 data barrier
    {4'd4, 1'b0, 2'b00, 4'b0000, 3'b001, 6'b010000}, // R4 one final ack
    {4'd8, 1'b1, 2'b10, 4'b0000, 3'b000, 6'b010000}, // R8 second request held
    {4'd8, 1'b1, 2'b10, 4'b0000, 3'b001, 6'b010000}, // R8 last ack, still held
    {4'd8, 1'b1, 2'b10, 4'b0000, 3'b000, 6'b100010}, // R8 first completes
    {4'd8, 1'b1, 2'b10, 4'b0000, 3'b000, 6'b011100}, // R8 second taken
    {4'd4, 1'b0, 2'b00, 4'b0000, 3'b000, 6'b100010},
    {4'd5, 1'b0, 2'b00, 4'b1111, 3'b000, 6'b100000}, // R5 type 11 write
    {4'd3, 1'b1, 2'b10, 4'b0000, 3'b000, 6'b011100},
    {4'd5, 1'b0, 2'b00, 4'b0000, 3'b110, 6'b011100}, // R5 wrong-level acks
    {4'd5, 1'b0, 2'b00, 4'b0000, 3'b001, 6'b011100}, // R5 final ack
    {4'd4, 1'b0, 2'b00, 4'b0000, 3'b000, 6'b100010}
  };

  function automatic logic [5:0] outs();
    return {bar_ready, mem_stall, insn_stall, irq_stall, bar_done, pipe_flush};
  endfunction

  task automatic check(input logic [5:0] exp, input string req);
    checks++;
    if (outs() !== exp) begin
      errors++;
      $display("FAIL %s: outputs %b expected %b at %0t", req, outs(), exp, $time);
    end
  endtask

  task automatic idle_inputs();
    bar_valid = 0; bar_op = 2'b00; mem_start = 0; mem_is_write = 0;
    mem_type = 2'b00; ack_local = 0; ack_ic = 0; ack_fin = 0;
  endtask

  // drive at the negedge, then check one posedge later at the next negedge
  task automatic step(input logic [19:0] v);
    {bar_valid, bar_op, mem_start, mem_is_write, mem_type} = v[15:9];
    {ack_local, ack_ic, ack_fin} = v[8:6];
    @(negedge clk);
    check(v[5:0], $sformatf("R%0d", v[19:16]));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not end, got %0d expected 0 pending cycles", 1);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    idle_inputs();
    rst = 1;
    repeat (3) @(negedge clk);
    check(6'b100000, "R9 reset state");
    rst = 0;

    for (int i = 0; i < NV; i++) step(VEC[i]);

    // R6: 17 non-shared writes saturate the counter at 15
    for (int i = 0; i < 17; i++) step({4'd6, 1'b0, 2'b00, 4'b1100, 3'b000, 6'b100000});
    step({4'd6, 1'b1, 2'b10, 4'b0000, 3'b000, 6'b011100});
    for (int i = 0; i < 15; i++) step({4'd6, 1'b0, 2'b00, 4'b0000, 3'b100, 6'b011100});
    step({4'd6, 1'b0, 2'b00, 4'b0000, 3'b000, 6'b100010}); // R6 empty after 15 acks

    // R6: ack on an empty counter does not wrap
    step({4'd6, 1'b0, 2'b00, 4'b0000, 3'b100, 6'b100000});
    step({4'd6, 1'b1, 2'b01, 4'b0000, 3'b000, 6'b010000});
    step({4'd6, 1'b0, 2'b00, 4'b0000, 3'b000, 6'b100010});

    // R9: reset in the middle of a drain clears it and the counters
    step({4'd9, 1'b0, 2'b00, 4'b1110, 3'b000, 6'b100000});
    step({4'd9, 1'b1, 2'b10, 4'b0000, 3'b000, 6'b011100});
    idle_inputs();
    rst = 1;
    @(negedge clk);
    check(6'b100000, "R9 reset while pending");
    rst = 0;
    step({4'd9, 1'b1, 2'b01, 4'b0000, 3'b000, 6'b010000});
    step({4'd9, 1'b0, 2'b00, 4'b0000, 3'b000, 6'b100010}); // R9 counters cleared

    idle_inputs();
    @(negedge clk);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule